// File: doc/BRIEF.md
# Multi-Line Serial Register Bank

This block is the host-side register file for a group of serial lines (up to 16). Each line exposes four 16-bit registers to a simple single-cycle bus: a receive control/status word, a receive buffer, a transmit control/status word and a transmit buffer. The block works out which line and which register an access targets from the bus address. It keeps each line's done and interrupt-enable flags and its per-line receive and transmit interrupt requests. Bit timing belongs to the serializers outside the block.

Characters arrive per line on a valid/ready port. `rx_ready` is high whenever the line is out of reset, so the receiver never stalls a sender. A character offered while `rx_ready` is low is dropped. A character that arrives before the host has read the previous one replaces it and is marked as an overrun. On the transmit side there is no back-pressure either. A host write to the transmit buffer raises a one-cycle `tx_start` with the character. The serializer answers with a one-cycle `tx_done` when the character has gone out.

Reads are combinational: `bus_rdata` is valid in the cycle of the access. Their side effects take hold at the clock edge that ends the access.

Top module: `sl_regbank`

## Requirements
- R1: A byte address in the window [BASE, BASE + 8*NLINES) selects line (addr-BASE)>>3, and address bits [2:1] select the register: 0 = receive CSR, 1 = receive buffer, 2 = transmit CSR, 3 = transmit buffer. Reads outside the window return 0 and writes outside it change nothing.
- R2: In both CSRs bit 7 is done and bit 6 is interrupt enable. The transmit CSR also holds maintenance (bit 2) and transmit break (bit 0) as read/write bits. All other bits read 0. After reset the receive CSR reads 0x0000 and the transmit CSR reads 0x0080.
- R3: A received character appears in receive-buffer bits 7:0 with bits 15:13 clear and sets receive done. If done was already set, the buffer instead reads with bit 15 (error) and bit 14 (overrun) set, and done stays set.
- R4: A received break loads the buffer with error (bit 15) and break (bit 13) set and data 0x00.
- R5: Reading the receive buffer clears receive done and withdraws the line's receive interrupt request.
- R6: In either CSR, writing interrupt enable as 0 withdraws that CSR's request, and writing it as 1 while done is set raises the request. At all times a request equals done AND enable.
- R7: A character arriving while receive interrupt enable is set raises `rx_irq` for that line.
- R8: Any write to the transmit buffer clears transmit done and the transmit request, and pulses `tx_start` for one cycle, in the cycle after the write, with the buffer on `tx_char`. Only an even-byte write (address bit 0 = 0) loads bits 7:0 into the buffer.
- R9: A `tx_done` pulse sets transmit done and raises `tx_irq` if enabled. If a transmit-buffer write lands in the same cycle, the write wins and done stays clear.
- R10: Odd-byte writes to either CSR and all writes to the receive buffer have no effect.
- R11: A `line_rst` pulse clears both buffers and the receive CSR, leaves the transmit CSR at 0x0080, and withdraws both requests of that line only.
- R12: `rx_ready` is low during reset and during a line's `line_rst`, and a character offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| rx_valid | input | NLINES | Per-line character offered |
| rx_ready | output | NLINES | Per-line character accepted |
| rx_data | input | 8*NLINES | Per-line received character |
| rx_brk | input | NLINES | Per-line offered item is a break |
| tx_start | output | NLINES | Per-line one-cycle transmit request |
| tx_char | output | 8*NLINES | Per-line character to send |
| tx_brk | output | NLINES | Per-line transmit-break control bit |
| tx_maint | output | NLINES | Per-line maintenance control bit |
| tx_done | input | NLINES | Per-line transmission finished pulse |
| line_rst | input | NLINES | Per-line synchronous reset |
| rx_irq | output | NLINES | Per-line receive interrupt request |
| tx_irq | output | NLINES | Per-line transmit interrupt request |

## Verification
The embedded properties watch several rules on every cycle:
- each request flop stays equal to done AND enable;
- a character landing on a full buffer sets the overrun and error flags;
- a buffer read or buffer write clears done in the next cycle;
- a completion sets transmit done;
- a line reset leaves its line in the cleared state.

Other behaviour only the directed scenarios can show:
- the address decode across lines and outside the window;
- the exact bit layout read back over the bus;
- that an odd-byte transmit write starts a transmission but keeps the old character;
- that ignored writes leave readable state untouched;
- the collision of a buffer write with a completion.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int WORD_W    = 16;
  localparam int CHAR_W    = 8;
  localparam int BIT_DONE  = 7;
  localparam int BIT_IE    = 6;
  localparam int BIT_MAINT = 2;
  localparam int BIT_XBRK  = 0;
  localparam int BIT_ERR   = 15;
  localparam int BIT_OVR   = 14;
  localparam int BIT_BRK   = 13;

  typedef enum logic [1:0] {
    RSEL_RXCSR = 2'd0,
    RSEL_RXBUF = 2'd1,
    RSEL_TXCSR = 2'd2,
    RSEL_TXBUF = 2'd3
  } rsel_e;
endpackage

// File: rtl/sl_addr_dec.sv
module sl_addr_dec
  import sl_pkg::*;
#(
  parameter int          NLINES = 4,
  parameter int          ADDR_W = 16,
  parameter int unsigned BASE   = 'h100,
  localparam int         LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [LW-1:0]     line,
  output rsel_e             sel,
  output logic              odd
);
  localparam int SPAN = NLINES * 8;
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  logic [ADDR_W-1:0] offs;

  always_comb begin
    offs = addr - BASE_V;
    hit  = (addr >= BASE_V) && (int'({1'b0, offs}) < SPAN);
    line = offs[3 +: LW];
    sel  = rsel_e'(offs[2:1]);
    odd  = offs[0];
  end
endmodule

// File: rtl/sl_rx_line.sv
module sl_rx_line
  import sl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_rst,
  input  logic              csr_wr,
  input  logic              ie_wdata,
  input  logic              buf_rd,
  input  logic              char_vld,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              char_brk,
  output logic              done,
  output logic              ie,
  output logic              err,
  output logic              ovr,
  output logic              brk,
  output logic [CHAR_W-1:0] data,
  output logic              irq
);
  logic              done_n, ie_n, err_n, ovr_n, brk_n, irq_n;
  logic [CHAR_W-1:0] data_n;

  // Order inside one cycle: CSR write, then buffer read, then arrival.
  always_comb begin
    done_n = done;
    ie_n   = ie;
    err_n  = err;
    ovr_n  = ovr;
    brk_n  = brk;
    data_n = data;
    irq_n  = irq;
    if (csr_wr) begin
      ie_n = ie_wdata;
      if (!ie_wdata)  irq_n = 1'b0;
      else if (done)  irq_n = 1'b1;
    end
    if (buf_rd) begin
      done_n = 1'b0;
      irq_n  = 1'b0;
    end
    if (char_vld) begin
      data_n = char_brk ? '0 : char_in;
      brk_n  = char_brk;
      err_n  = char_brk;
      ovr_n  = 1'b0;
      if (done_n) begin
        err_n = 1'b1;
        ovr_n = 1'b1;
      end else begin
        done_n = 1'b1;
      end
      if (ie_n) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; ie <= 1'b0; err <= 1'b0; ovr <= 1'b0;
      brk  <= 1'b0; data <= '0; irq <= 1'b0;
    end else if (line_rst) begin
      done <= 1'b0; ie <= 1'b0; err <= 1'b0; ovr <= 1'b0;
      brk  <= 1'b0; data <= '0; irq <= 1'b0;
    end else begin
      done <= done_n; ie <= ie_n; err <= err_n; ovr <= ovr_n;
      brk  <= brk_n;  data <= data_n; irq <= irq_n;
    end
  end

  // R3
  rx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && done && !buf_rd && !line_rst) |=> (ovr && err && done));
  // R5
  rx_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !char_vld && !line_rst) |=> (!done && !irq));
  // R7
  rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (done && ie));
  // R11
  rx_lrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_rst |=> (!done && !irq && !err && data == '0));
endmodule

// File: rtl/sl_tx_line.sv
module sl_tx_line
  import sl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_rst,
  input  logic              csr_wr,
  input  logic              ie_wdata,
  input  logic              maint_wdata,
  input  logic              xbrk_wdata,
  input  logic              buf_wr,
  input  logic              buf_even,
  input  logic [CHAR_W-1:0] char_wdata,
  input  logic              tx_cmpl,
  output logic              done,
  output logic              ie,
  output logic              maint,
  output logic              xbrk,
  output logic [CHAR_W-1:0] data,
  output logic              irq,
  output logic              start
);
  logic              done_n, ie_n, irq_n;
  logic [CHAR_W-1:0] data_n;

  // A buffer write in the same cycle as a completion wins.
  always_comb begin
    done_n = done;
    ie_n   = ie;
    irq_n  = irq;
    data_n = data;
    if (csr_wr) begin
      ie_n = ie_wdata;
      if (!ie_wdata)  irq_n = 1'b0;
      else if (done)  irq_n = 1'b1;
    end
    if (buf_wr) begin
      if (buf_even) data_n = char_wdata;
      done_n = 1'b0;
      irq_n  = 1'b0;
    end else if (tx_cmpl) begin
      done_n = 1'b1;
      if (ie_n) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b1; ie <= 1'b0; maint <= 1'b0; xbrk <= 1'b0;
      data <= '0;   irq <= 1'b0; start <= 1'b0;
    end else if (line_rst) begin
      done <= 1'b1; ie <= 1'b0; maint <= 1'b0; xbrk <= 1'b0;
      data <= '0;   irq <= 1'b0; start <= 1'b0;
    end else begin
      done  <= done_n;
      ie    <= ie_n;
      irq   <= irq_n;
      data  <= data_n;
      start <= buf_wr;
      if (csr_wr) begin
        maint <= maint_wdata;
        xbrk  <= xbrk_wdata;
      end
    end
  end

  // R8
  tx_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && !line_rst) |=> (start && !done && !irq));
  // R9
  tx_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cmpl && !buf_wr && !line_rst) |=> done);
  // R6
  tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (done && ie));
  // R11
  tx_lrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_rst |=> (done && !irq && !start && data == '0));
endmodule

// File: rtl/sl_regbank.sv
module sl_regbank
  import sl_pkg::*;
#(
  parameter int          NLINES = 4,
  parameter int          ADDR_W = 16,
  parameter int unsigned BASE   = 'h100
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  input  logic [NLINES-1:0]        rx_valid,
  output logic [NLINES-1:0]        rx_ready,
  input  logic [NLINES*CHAR_W-1:0] rx_data,
  input  logic [NLINES-1:0]        rx_brk,
  output logic [NLINES-1:0]        tx_start,
  output logic [NLINES*CHAR_W-1:0] tx_char,
  output logic [NLINES-1:0]        tx_brk,
  output logic [NLINES-1:0]        tx_maint,
  input  logic [NLINES-1:0]        tx_done,
  input  logic [NLINES-1:0]        line_rst,
  output logic [NLINES-1:0]        rx_irq,
  output logic [NLINES-1:0]        tx_irq
);
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1;

  logic          hit, odd;
  logic [LW-1:0] line;
  rsel_e         sel;
  logic          up_q;
  logic          unused_wdata;

  logic [WORD_W-1:0] rxcsr_w [NLINES];
  logic [WORD_W-1:0] rxbuf_w [NLINES];
  logic [WORD_W-1:0] txcsr_w [NLINES];
  logic [WORD_W-1:0] txbuf_w [NLINES];

  assign unused_wdata = ^{bus_wdata[15:8], bus_wdata[5:3], bus_wdata[1]};

  sl_addr_dec #(.NLINES(NLINES), .ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr (bus_addr),
    .hit  (hit),
    .line (line),
    .sel  (sel),
    .odd  (odd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic              mine, rx_csr_wr, rx_buf_rd, tx_csr_wr, tx_buf_wr, chv;
    logic              r_done, r_ie, r_err, r_ovr, r_brk;
    logic [CHAR_W-1:0] r_data;
    logic              t_done, t_ie;
    logic [CHAR_W-1:0] t_data;

    assign mine      = bus_sel && hit && (line == LW'(i));
    assign rx_csr_wr = mine && bus_wr && !odd && (sel == RSEL_RXCSR);
    assign rx_buf_rd = mine && !bus_wr && (sel == RSEL_RXBUF);
    assign tx_csr_wr = mine && bus_wr && !odd && (sel == RSEL_TXCSR);
    assign tx_buf_wr = mine && bus_wr && (sel == RSEL_TXBUF);
    assign rx_ready[i] = up_q && !line_rst[i];
    assign chv         = rx_valid[i] && rx_ready[i];

    sl_rx_line u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_rst (line_rst[i]),
      .csr_wr   (rx_csr_wr),
      .ie_wdata (bus_wdata[BIT_IE]),
      .buf_rd   (rx_buf_rd),
      .char_vld (chv),
      .char_in  (rx_data[i*CHAR_W +: CHAR_W]),
      .char_brk (rx_brk[i]),
      .done     (r_done),
      .ie       (r_ie),
      .err      (r_err),
      .ovr      (r_ovr),
      .brk      (r_brk),
      .data     (r_data),
      .irq      (rx_irq[i])
    );

    sl_tx_line u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_rst    (line_rst[i]),
      .csr_wr      (tx_csr_wr),
      .ie_wdata    (bus_wdata[BIT_IE]),
      .maint_wdata (bus_wdata[BIT_MAINT]),
      .xbrk_wdata  (bus_wdata[BIT_XBRK]),
      .buf_wr      (tx_buf_wr),
      .buf_even    (!odd),
      .char_wdata  (bus_wdata[CHAR_W-1:0]),
      .tx_cmpl     (tx_done[i]),
      .done        (t_done),
      .ie          (t_ie),
      .maint       (tx_maint[i]),
      .xbrk        (tx_brk[i]),
      .data        (t_data),
      .irq         (tx_irq[i]),
      .start       (tx_start[i])
    );

    assign tx_char[i*CHAR_W +: CHAR_W] = t_data;

    always_comb begin
      rxcsr_w[i] = '0;
      rxcsr_w[i][BIT_DONE] = r_done;
      rxcsr_w[i][BIT_IE]   = r_ie;
      rxbuf_w[i] = '0;
      rxbuf_w[i][BIT_ERR]  = r_err;
      rxbuf_w[i][BIT_OVR]  = r_ovr;
      rxbuf_w[i][BIT_BRK]  = r_brk;
      rxbuf_w[i][CHAR_W-1:0] = r_data;
      txcsr_w[i] = '0;
      txcsr_w[i][BIT_DONE]  = t_done;
      txcsr_w[i][BIT_IE]    = t_ie;
      txcsr_w[i][BIT_MAINT] = tx_maint[i];
      txcsr_w[i][BIT_XBRK]  = tx_brk[i];
      txbuf_w[i] = '0;
      txbuf_w[i][CHAR_W-1:0] = t_data;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && hit) begin
      for (int i = 0; i < NLINES; i++) begin
        if (line == LW'(i)) begin
          case (sel)
            RSEL_RXCSR: bus_rdata = rxcsr_w[i];
            RSEL_RXBUF: bus_rdata = rxbuf_w[i];
            RSEL_TXCSR: bus_rdata = txcsr_w[i];
            default:    bus_rdata = txbuf_w[i];
          endcase
        end
      end
    end
  end
endmodule

// File: tb/sim_sl_regbank.sv
module sim_sl_regbank;
  localparam int N    = 4;
  localparam int BASE = 'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [N-1:0]   rx_valid = '0, rx_brk = '0, tx_done = '0, line_rst = '0;
  logic [N-1:0]   rx_ready, tx_start, tx_brk, tx_maint, rx_irq, tx_irq;
  logic [N*8-1:0] rx_data = '0;
  logic [N*8-1:0] tx_char;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sl_regbank #(.NLINES(N), .ADDR_W(16), .BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_brk(rx_brk),
    .tx_start(tx_start), .tx_char(tx_char), .tx_brk(tx_brk), .tx_maint(tx_maint),
    .tx_done(tx_done), .line_rst(line_rst), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  function automatic logic [15:0] ra(int ln, int r);
    return 16'(BASE + ln * 8 + r * 2);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic send(int ln, logic [7:0] c, logic b);
    @(negedge clk);
    rx_valid[ln] = 1'b1; rx_data[ln*8 +: 8] = c; rx_brk[ln] = b;
    @(negedge clk);
    rx_valid[ln] = 1'b0; rx_brk[ln] = 1'b0;
  endtask

  task automatic fin(int ln);
    @(negedge clk);
    tx_done[ln] = 1'b1;
    @(negedge clk);
    tx_done[ln] = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int l = 0; l < N; l++) begin
      rd(ra(l, 0), d); chk("R2 rx csr reset", d, 16'h0000);
      rd(ra(l, 2), d); chk("R2 tx csr reset", d, 16'h0080);
    end
    chk("R2 irq reset", {rx_irq, tx_irq}, '0);
    chk("R12 rx_ready after reset", rx_ready, 4'hF);
  endtask

  task automatic t_rx_basic;
    logic [15:0] d;
    send(1, 8'h41, 1'b0);
    rd(ra(1, 0), d); chk("R3 done set", d, 16'h0080);
    rd(ra(0, 0), d); chk("R1 other line untouched", d, 16'h0000);
    rd(ra(1, 1), d); chk("R3 buffer data", d, 16'h0041);
    rd(ra(1, 0), d); chk("R5 done cleared by read", d, 16'h0000);
  endtask

  task automatic t_rx_irq;
    logic [15:0] d;
    wr(ra(2, 0), 16'h0040);
    rd(ra(2, 0), d); chk("R2 rx ie readback", d, 16'h0040);
    send(2, 8'h33, 1'b0);
    chk("R7 rx irq raised", rx_irq, 4'b0100);
    rd(ra(2, 1), d); chk("R3 buffer line2", d, 16'h0033);
    chk("R5 rx irq withdrawn", rx_irq, 4'b0000);
    rd(ra(2, 0), d); chk("R5 csr after read", d, 16'h0040);
  endtask

  task automatic t_overrun;
    logic [15:0] d;
    send(0, 8'h11, 1'b0);
    send(0, 8'h22, 1'b0);
    rd(ra(0, 1), d); chk("R3 overrun flags", d, 16'hC022);
    send(0, 8'h55, 1'b0);
    rd(ra(0, 1), d); chk("R3 flags clear on fresh char", d, 16'h0055);
  endtask

  task automatic t_break;
    logic [15:0] d;
    send(3, 8'h7F, 1'b1);
    rd(ra(3, 1), d); chk("R4 break word", d, 16'hA000);
  endtask

  task automatic t_ie_rule;
    logic [15:0] d;
    send(1, 8'h10, 1'b0);
    chk("R6 no req while ie clear", rx_irq[1], 1'b0);
    wr(ra(1, 0), 16'h0040);
    chk("R6 rx ie=1 with done raises", rx_irq[1], 1'b1);
    wr(ra(1, 0), 16'h0000);
    chk("R6 rx ie=0 withdraws", rx_irq[1], 1'b0);
    rd(ra(1, 1), d);
    wr(ra(0, 2), 16'h0040);
    chk("R6 tx ie=1 with done raises", tx_irq[0], 1'b1);
    wr(ra(0, 2), 16'h0000);
    chk("R6 tx ie=0 withdraws", tx_irq[0], 1'b0);
  endtask

  task automatic t_tx;
    logic [15:0] d;
    wr(ra(2, 2), 16'h0045);
    rd(ra(2, 2), d); chk("R2 tx csr readback", d, 16'h00C5);
    chk("R6 tx irq on enable", tx_irq[2], 1'b1);
    chk("R2 tx control pins", {tx_maint[2], tx_brk[2]}, 2'b11);
    wr(ra(2, 3), 16'h005A);
    chk("R8 start pulse", tx_start, 4'b0100);
    chk("R8 start char", tx_char[2*8 +: 8], 8'h5A);
    chk("R8 tx irq withdrawn", tx_irq[2], 1'b0);
    @(negedge clk);
    chk("R8 start one cycle", tx_start, 4'b0000);
    rd(ra(2, 2), d); chk("R8 done cleared", d, 16'h0045);
    fin(2);
    rd(ra(2, 2), d); chk("R9 done on completion", d, 16'h00C5);
    chk("R9 tx irq on completion", tx_irq[2], 1'b1);
    rd(ra(2, 3), d); chk("R8 tx buffer", d, 16'h005A);
  endtask

  task automatic t_ignored;
    logic [15:0] d;
    wr(ra(2, 3) + 16'd1, 16'h0077);
    chk("R8 odd write starts", tx_start[2], 1'b1);
    rd(ra(2, 3), d); chk("R8 odd write keeps char", d, 16'h005A);
    rd(ra(2, 2), d); chk("R8 odd write clears done", d, 16'h0045);
    fin(2);
    wr(ra(0, 2) + 16'd1, 16'h0040);
    rd(ra(0, 2), d); chk("R10 odd tx csr write ignored", d, 16'h0080);
    chk("R10 no tx irq", tx_irq[0], 1'b0);
    wr(ra(3, 0) + 16'd1, 16'h0040);
    rd(ra(3, 0), d); chk("R10 odd rx csr write ignored", d, 16'h0000);
    send(1, 8'h21, 1'b0);
    wr(ra(1, 1), 16'hFFFF);
    rd(ra(1, 0), d); chk("R10 rx buf write keeps done", d, 16'h0080);
    rd(ra(1, 1), d); chk("R10 rx buf write keeps data", d, 16'h0021);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ra(3, 3); bus_wdata = 16'h0066;
    tx_done[3] = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tx_done[3] = 1'b0;
    rd(ra(3, 2), d); chk("R9 write beats completion", d, 16'h0000);
    fin(3);
    rd(ra(3, 2), d); chk("R9 later completion", d, 16'h0080);
  endtask

  task automatic t_range;
    logic [15:0] d;
    rd(16'(BASE + N * 8), d); chk("R1 read above window", d, 16'h0000);
    rd(16'(BASE - 8), d); chk("R1 read below window", d, 16'h0000);
    wr(16'(BASE + N * 8 + 4), 16'h0040);
    chk("R1 write above window ignored", tx_irq[0], 1'b0);
    rd(ra(0, 2), d); chk("R1 line0 tx csr unchanged", d, 16'h0080);
  endtask

  task automatic t_linerst;
    logic [15:0] d;
    send(2, 8'h44, 1'b0);
    @(negedge clk);
    line_rst[2] = 1'b1; rx_valid[2] = 1'b1; rx_data[16 +: 8] = 8'h99;
    #5 chk("R12 rx_ready low in line reset", rx_ready, 4'b1011);
    @(negedge clk);
    line_rst[2] = 1'b0; rx_valid[2] = 1'b0;
    chk("R11 irqs withdrawn", {rx_irq[2], tx_irq[2]}, 2'b00);
    rd(ra(2, 0), d); chk("R11 rx csr cleared", d, 16'h0000);
    rd(ra(2, 1), d); chk("R12 rx buf cleared, char ignored", d, 16'h0000);
    rd(ra(2, 2), d); chk("R11 tx csr", d, 16'h0080);
    rd(ra(2, 3), d); chk("R11 tx buf cleared", d, 16'h0000);
    rd(ra(3, 2), d); chk("R11 other line kept", d, 16'h0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 rx_ready low in reset", rx_ready, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_basic();
    t_rx_irq();
    t_overrun();
    t_break();
    t_ie_rule();
    t_tx();
    t_ignored();
    t_collide();
    t_range();
    t_linerst();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule